// File: doc/BRIEF.md
# Debounced Switch Blink-Rate Controller

This block watches a periodic tick pulse from an interval timer and inverts an LED output once every 250 ticks. Each time the LED inverts, it also hands the timer a fresh 16-bit reload value, qualified by a single-cycle load strobe. The timer thus picks up a new period only at a toggle instant, never part-way through a blink.

A push-button input selects the blink rate. The pin is brought into the clock domain by a two-flop synchronizer. A selectable edge detector then starts a debounce wait that is measured in ticks. The wait is longer when the ticks are shorter, so it always spans roughly 10 ms. If the switch still sits at the level that followed the edge when the wait ends, the press is accepted and the rate steps to the next of four settings, wrapping back to the first. Tick counting and LED toggling carry on while a debounce wait is open.

Top module: `blink_rate_ctrl`

## Requirements
- R1: Every asserted `tick_in` advances a tick count. On the 250th tick, `led_out` inverts and the count restarts from zero. `led_out` changes at no other time.
- R2: On the clock edge that sees the 250th tick, `reload_load` goes high for exactly one cycle, and `reload_val` takes the pending reload value. `reload_val` keeps its value at all other times.
- R3: `edge_sel` chooses which synchronized switch transitions open a debounce wait: 2'b00 none, 2'b01 high-to-low, 2'b10 low-to-high, 2'b11 either.
- R4: `switch_in` passes through two synchronizer flops. The edge is judged between the second flop and a copy of it delayed by one cycle. The synchronizer flops and the delayed copy reset to 1.
- R5: A debounce wait ends on its Nth tick, where N is 6, 11, 21 or 41 for rate settings 0, 1, 2 and 3. The press is accepted only if, at that tick, the synchronized switch equals the level captured at the edge.
- R6: An accepted press steps the rate setting 0→1→2→3→0. The pending reload values for these settings are 63999, 31999, 15999 and 7999. A new value reaches `reload_val` only at the next toggle.
- R7: After reset, `led_out` = 0, `reload_load` = 0 and `reload_val` = 63999. The tick count, the rate setting and the debounce state are all cleared.
- R8: Ticks that arrive during a debounce wait are still counted toward the 250-tick toggle.
- R9: Edges detected while a debounce wait is open are discarded. They never start or extend a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | 1 | One-cycle pulse per timer interval |
| switch_in | input | 1 | Asynchronous push-button level (idle high) |
| edge_sel | input | 2 | Valid-edge select for press detection |
| led_out | output | 1 | LED drive, inverts every 250 ticks |
| reload_val | output | 16 | Reload value presented to the timer |
| reload_load | output | 1 | One-cycle strobe to write `reload_val` into the timer |

## Verification
Every output is registered. `led_out`, `reload_val` and `reload_load` therefore change on the clock edge that samples the 250th tick, and are read at the next falling edge. A pin change on `switch_in` reaches the edge compare two edges later, and the wait opens on the third. The accepting tick updates the rate setting on its own edge, but that setting is seen at the ports only at the next toggle. A behavioural model in the bench steps through this same per-edge schedule and is compared with the outputs at every falling edge. Directed checks then probe the deferral, rejection, discard and wrap cases at the points where each result is due.

// File: rtl/blink_rate_pkg.sv
// Shared types and table generators for the blink-rate controller.
// Assumes: rate tables are derived by halving/doubling a base value per step.
package blink_rate_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    typedef enum logic {
        DB_IDLE = 1'b0,
        DB_WAIT = 1'b1
    } db_state_t;

    // Reload for rate step idx: period halves per step.
    function automatic int unsigned halved_reload(int unsigned base, int unsigned idx);
        return (base >> idx) - 1;
    endfunction

    // Debounce length in ticks for rate step idx: doubles per step.
    function automatic int unsigned scaled_wait(int unsigned base, int unsigned idx);
        return (base << idx) + 1;
    endfunction

endpackage

// File: rtl/sw_edge_detect.sv
// Synchronizes the switch pin and flags transitions selected by edge_sel.
// Assumes: switch idles high; SYNC_STAGES >= 2.
module sw_edge_detect
    import blink_rate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       switch_in,
    input  logic [1:0] edge_sel,
    output logic       sw_level,
    output logic       edge_hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   fall_seen;
    logic                   rise_seen;

    // Synchronizer chain, one flop per stage (R4).
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= switch_in;
                end
            end else begin : g_next
                // Later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign sw_level = sync_q[SYNC_STAGES-1];

    // One-cycle delayed copy of the synchronized level for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sw_level;
    end

    // Edge qualification per selected mode (R3).
    always_comb begin
        fall_seen = prev_q & ~sw_level;
        rise_seen = ~prev_q & sw_level;
        edge_hit  = (edge_sel[0] & fall_seen) | (edge_sel[1] & rise_seen);
    end

endmodule

// File: rtl/press_debouncer.sv
// Tick-timed debounce and rate-step selection.
// Assumes: tick_in is a single-cycle pulse; STEPS is a power of two.
module press_debouncer
    import blink_rate_pkg::*;
#(
    parameter int STEPS       = 4,
    parameter int WAIT_BASE   = 5,
    parameter int RELOAD_BASE = 64000,
    parameter int RW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic          edge_hit,
    input  logic          sw_level,
    output logic [RW-1:0] pending_val,
    output logic          busy
);

    localparam int IDX_W    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int WAIT_MAX = (WAIT_BASE << (STEPS - 1)) + 1;
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);

    logic [RW-1:0]     reload_tab [STEPS];
    logic [WCNT_W-1:0] wait_tab   [STEPS];

    db_state_t         state_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic              lvl_q;
    logic [IDX_W-1:0]  press_q;
    logic              wait_last;
    logic              accept;

    // Per-step reload and wait-length tables, computed from the bases.
    generate
        for (genvar g = 0; g < STEPS; g++) begin : g_tab
            assign reload_tab[g] = RW'(halved_reload(RELOAD_BASE, g));
            assign wait_tab[g]   = WCNT_W'(scaled_wait(WAIT_BASE, g));
        end
    endgenerate

    // Final tick of the open wait, and the acceptance test (R5).
    always_comb begin
        wait_last = (state_q == DB_WAIT) && tick_in &&
                    (wcnt_q == wait_tab[press_q] - WCNT_W'(1));
        accept    = wait_last && (sw_level == lvl_q);
    end

    // Wait state machine; edges while waiting are dropped (R9), ticks keep counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            wcnt_q  <= '0;
            lvl_q   <= 1'b0;
        end else if (wait_last) begin
            state_q <= DB_IDLE;
        end else if (state_q == DB_IDLE && edge_hit) begin
            state_q <= DB_WAIT;
            wcnt_q  <= '0;
            lvl_q   <= sw_level;
        end else if (state_q == DB_WAIT && tick_in) begin
            wcnt_q  <= wcnt_q + WCNT_W'(1);
        end
    end

    // Rate step advances and wraps on an accepted press (R6).
    always_ff @(posedge clk) begin
        if (!rst_n)      press_q <= '0;
        else if (accept) press_q <= (press_q == IDX_W'(STEPS - 1)) ? '0 : press_q + IDX_W'(1);
    end

    assign pending_val = reload_tab[press_q];
    assign busy        = (state_q == DB_WAIT);

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wcnt_q < wait_tab[press_q])); // R5

    AST_STEP_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (press_q != $past(press_q)) |-> ($past(state_q == DB_WAIT) && $past(tick_in))); // R5

endmodule

// File: rtl/tick_toggler.sv
// Counts ticks, inverts the LED and strobes the reload value each full cycle.
// Assumes: TOGGLE_TICKS >= 2 so load strobes never sit back to back.
module tick_toggler #(
    parameter int          TOGGLE_TICKS = 250,
    parameter int          RW           = 16,
    parameter logic [15:0] RESET_RELOAD = 16'd63999
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic [RW-1:0] pending_val,
    output logic          led_out,
    output logic [RW-1:0] reload_val,
    output logic          reload_load
);

    localparam int CNT_W = $clog2(TOGGLE_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOGGLE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick count, LED inversion and reload handoff on the final tick (R1, R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            led_out     <= 1'b0;
            reload_val  <= RW'(RESET_RELOAD);
            reload_load <= 1'b0;
        end else if (tick_in && cnt_q == CNT_LAST) begin
            cnt_q       <= '0;
            led_out     <= ~led_out;
            reload_val  <= pending_val;
            reload_load <= 1'b1;
        end else begin
            if (tick_in) cnt_q <= cnt_q + CNT_W'(1);
            reload_load <= 1'b0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R1

    AST_LED_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_out) |-> reload_load); // R1

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_load |=> !reload_load); // R2

endmodule

// File: rtl/blink_rate_ctrl.sv
// Top: switch-selected blink rate with reload handed to the timer at toggles.
// Assumes: tick_in comes from an interval timer in the same clock domain.
module blink_rate_ctrl
    import blink_rate_pkg::*;
#(
    parameter int TOGGLE_TICKS = 250,
    parameter int STEPS        = 4,
    parameter int WAIT_BASE    = 5,
    parameter int RELOAD_BASE  = 64000,
    parameter int RW           = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic          switch_in,
    input  logic [1:0]    edge_sel,
    output logic          led_out,
    output logic [RW-1:0] reload_val,
    output logic          reload_load
);

    localparam logic [15:0] RESET_RELOAD = 16'(halved_reload(RELOAD_BASE, 0));

    logic          sw_level;
    logic          edge_hit;
    logic [RW-1:0] pending_val;
    logic          busy;

    sw_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .switch_in(switch_in),
        .edge_sel (edge_sel),
        .sw_level (sw_level),
        .edge_hit (edge_hit)
    );

    press_debouncer #(
        .STEPS      (STEPS),
        .WAIT_BASE  (WAIT_BASE),
        .RELOAD_BASE(RELOAD_BASE),
        .RW         (RW)
    ) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .edge_hit   (edge_hit),
        .sw_level   (sw_level),
        .pending_val(pending_val),
        .busy       (busy)
    );

    tick_toggler #(
        .TOGGLE_TICKS(TOGGLE_TICKS),
        .RW          (RW),
        .RESET_RELOAD(RESET_RELOAD)
    ) u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .pending_val(pending_val),
        .led_out    (led_out),
        .reload_val (reload_val),
        .reload_load(reload_load)
    );

    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reload_val) |-> reload_load); // R2

    AST_OFF_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_OFF && !busy) |=> !busy); // R3

endmodule

// File: tb/blink_rate_ctrl_tb.sv
`timescale 1ns/1ps
module blink_rate_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        switch_in = 1'b1;
    logic [1:0]  edge_sel = 2'b01;
    logic        led_out;
    logic [15:0] reload_val;
    logic        reload_load;

    int vectors = 0;
    int fails = 0;
    int tick_gap = 0;
    int gap_cnt = 0;
    int cyc = 0;
    int last_load = -1;
    int load_diff = 0;
    int load_count = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    bit m_s1, m_s2, m_prev, m_busy, m_lvl, m_led, m_load;
    int m_wcnt, m_press, m_tcnt, m_rval;

    always #2 clk = ~clk;

    blink_rate_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .switch_in  (switch_in),
        .edge_sel   (edge_sel),
        .led_out    (led_out),
        .reload_val (reload_val),
        .reload_load(reload_load)
    );

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Behavioural reference, stepped once per rising edge.
    always @(posedge clk) begin
        int  wlen;
        bit  hit, fin, acc, tog;
        cyc++;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1;              // R4 reset level
            m_busy = 0; m_wcnt = 0; m_lvl = 0; m_press = 0;
            m_tcnt = 0; m_led = 0; m_rval = 63999; m_load = 0;
        end else begin
            hit  = (edge_sel[0] && m_prev && !m_s2) || (edge_sel[1] && !m_prev && m_s2);
            wlen = 5 * (1 << m_press) + 1;
            fin  = m_busy && tick_in && (m_wcnt == wlen - 1);
            acc  = fin && (m_s2 == m_lvl);
            tog  = tick_in && (m_tcnt == 249);
            m_load = tog;
            if (tog) begin
                m_led  = !m_led;
                m_rval = (64000 >> m_press) - 1;
            end
            if (tick_in) m_tcnt = tog ? 0 : m_tcnt + 1;
            if (fin) m_busy = 0;
            else if (!m_busy && hit) begin m_busy = 1; m_wcnt = 0; m_lvl = m_s2; end
            else if (m_busy && tick_in) m_wcnt++;
            if (acc) m_press = (m_press + 1) % 4;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = switch_in;  // R4 two-flop path
        end
    end

    // Per-cycle compare against the model and load bookkeeping.
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R1,R8 led_out", int'(led_out), int'(m_led));
            check("R2 reload_load", int'(reload_load), int'(m_load));
            check("R2,R6 reload_val", int'(reload_val), m_rval);
            if (reload_load) begin
                if (last_load >= 0) load_diff = cyc - last_load;
                last_load = cyc;
                load_count++;
            end
        end
    end

    // Tick generator: one pulse every tick_gap cycles (0 = none).
    always @(negedge clk) begin
        if (tick_gap == 0) tick_in <= 1'b0;
        else begin
            tick_in <= (gap_cnt == 0);
            gap_cnt <= (gap_cnt + 1 >= tick_gap) ? 0 : gap_cnt + 1;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_load();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (reload_load) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 led_out", int'(led_out), 0);
        check("R7 reload_load", int'(reload_load), 0);
        check("R7 reload_val", int'(reload_val), 63999);
        cmp_en = 1'b1;

        // R1 toggle spacing with a tick every cycle
        tick_gap = 1;
        run(520);
        check("R1 load count", load_count, 2);
        check("R1 load spacing", load_diff, 250);

        // R6 falling-edge press steps to 31999, deferred to toggle
        switch_in = 1'b0; run(60); switch_in = 1'b1; run(5);
        check("R6 deferred reload_val", int'(reload_val), 63999);
        wait_load();
        check("R6 step 1 reload_val", int'(reload_val), 31999);

        // R5 bounce released before wait end is rejected
        switch_in = 1'b0; run(5); switch_in = 1'b1; run(40);
        wait_load();
        check("R5 bounce rejected", int'(reload_val), 31999);

        // R9 second edge inside the wait is discarded
        switch_in = 1'b0; run(3); switch_in = 1'b1; run(2);
        switch_in = 1'b0; run(40); switch_in = 1'b1; run(5);
        wait_load();
        check("R9 single step", int'(reload_val), 15999);

        // R3 detection disabled, then rising-edge mode
        edge_sel = 2'b00;
        switch_in = 1'b0; run(40); switch_in = 1'b1; run(40);
        wait_load();
        check("R3 off ignored", int'(reload_val), 15999);
        edge_sel = 2'b10;
        switch_in = 1'b0; run(40);
        switch_in = 1'b1; run(100);
        wait_load();
        check("R3 rising accepted", int'(reload_val), 7999);

        // R8 sparse ticks, both edges: press wraps to 0, release steps to 1
        tick_gap = 3;
        edge_sel = 2'b11;
        switch_in = 1'b0; run(400);
        wait_load();
        check("R8,R6 wrap reload_val", int'(reload_val), 63999);
        switch_in = 1'b1; run(400);
        wait_load();
        check("R8 both-edge release", int'(reload_val), 31999);
        check("R1 sparse spacing", load_diff, 750);

        finish_run();
    end

endmodule